// File: doc/BRIEF.md
# Memory Test Address and Wait-State Sequencer

This block drives the address side of a self-test run on a single RAM. When a start request arrives, it captures a set of run settings: the array depth code, the sweep direction, the order of the two low column bits, the latency choice and a 4-bit data seed. It then walks every location of the array once. The column bits form the inner loop and the row bits the outer loop. It can sweep upward from location zero or downward from the last location.

Each location is held on the address bus with the access strobe high for a programmable number of wait states before the sequencer moves on. The wait-state count comes from one of two latency codes. A 4-bit code serves the wide array and a 2-bit code serves the narrow array. In both cases the minimum is two wait states.

The seed is copied across the whole background data bus. After the last location, a one-cycle end-of-pass pulse tells the pattern engine it can start its next sweep. Pattern selection and read-data comparison belong to the engine above this block.

Top module: `bist_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `access_o`, `pass_end_o`, `cfg_err_o` and `bg_data_o` are all 0.
- R2: The row code sets the row count: 000→16, 001→32, 010→64, 011→128, 100→256 and 101→512. A pass visits exactly rows × 2^COL_W locations, each one once.
- R3: A row code of 110 or 111 is treated as 512 rows. It sets `cfg_err_o` when the pass is accepted. The next accepted start with a legal code clears `cfg_err_o`.
- R4: The address is {row, column} with the column in the low COL_W bits. In an upward pass the logical index runs from 0 to the last location. When `lsb_alt_i`=0, the two low column bits follow 00, 01, 10, 11.
- R5: When `lsb_alt_i`=1, the two low column bits follow 00, 01, 11, 10 going up and 10, 11, 01, 00 going down.
- R6: When `dir_down_i`=1, the pass starts at the last logical index and steps down to 0. When `lsb_alt_i`=0, the low column bits go 11, 10, 01, 00.
- R7: When `lat_sel_i`=0, each location is held with `access_o` high for the number of cycles given by `data_lat_i`: codes 0 and 1 give 2 cycles, and codes 2 to 15 give code+1 cycles.
- R8: When `lat_sel_i`=1, the hold comes from `tag_lat_i`: 00→2, 01→2, 10→3 and 11→4 cycles.
- R9: `pass_end_o` is high for exactly one cycle, in the cycle right after the last access cycle, with `access_o` low. The block then stays idle.
- R10: `bg_data_o` bit b equals bit (b mod 4) of the seed captured at the accepted start. It holds that value through and after the pass.
- R11: While a pass runs, `start_i` and changes on every setting input have no effect on the address sequence, the hold length or `bg_data_o`.
- R12: The first location appears on `addr_o`, with `access_o` high, in the cycle after the clock edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted only while idle |
| dir_down_i | input | 1 | 1 = sweep from the last location down to 0 |
| row_code_i | input | 3 | Row depth code |
| lsb_alt_i | input | 1 | 1 = low column bits in reflected order |
| lat_sel_i | input | 1 | 0 = use the 4-bit latency code, 1 = use the 2-bit code |
| data_lat_i | input | 4 | Latency code for the wide array |
| tag_lat_i | input | 2 | Latency code for the narrow array |
| seed_i | input | 4 | Data background seed |
| addr_o | output | 9+COL_W | Physical address {row, column} |
| access_o | output | 1 | Access strobe, high during every wait state of a pass |
| bg_data_o | output | DATA_W | Seed copied across the data bus |
| pass_end_o | output | 1 | One-cycle end-of-pass pulse |
| cfg_err_o | output | 1 | A reserved row code was used for the current pass |

## Verification
The hardest cases to reach are the pass boundaries at the extremes. These are a downward pass through the reflected low-bit order on a 512-row array, and the reserved codes that must behave exactly like the 512-row code. The bench reaches them with a full sweep over every row code, both directions and both low-bit orders, using a 4-column geometry so that the largest arrays still fit the cycle budget. It compares every cycle of every pass against an arithmetic model. Separate passes walk all sixteen wide-array latency codes and all four narrow-array codes. One pass pulses start and changes every setting halfway through, so the bench can show the running sequence is not disturbed.

// File: rtl/bist_ag_pkg.sv
package bist_ag_pkg;

  localparam int ROW_CODE_W = 3;
  localparam int ROW_BITS   = 9;
  localparam int WAIT_W     = 5;

  function automatic logic [ROW_BITS:0] rows_of(input logic [ROW_CODE_W-1:0] code);
    logic [ROW_BITS:0] r;
    if (code > 3'd5) r = 10'd512;
    else             r = 10'd16 << code;
    return r;
  endfunction

  function automatic logic row_code_bad(input logic [ROW_CODE_W-1:0] code);
    return code > 3'd5;
  endfunction

  function automatic logic [WAIT_W-1:0] wide_waits(input logic [3:0] code);
    logic [WAIT_W-1:0] w;
    if (code < 4'd2) w = 5'd2;
    else             w = {1'b0, code} + 5'd1;
    return w;
  endfunction

  function automatic logic [WAIT_W-1:0] narrow_waits(input logic [1:0] code);
    logic [WAIT_W-1:0] w;
    if (code < 2'd2) w = 5'd2;
    else             w = {3'b000, code} + 5'd1;
    return w;
  endfunction

  function automatic logic [1:0] low_col(input logic [1:0] lin, input logic alt);
    logic [1:0] c;
    if (alt) c = {lin[1], lin[1] ^ lin[0]};
    else     c = lin;
    return c;
  endfunction

endpackage

// File: rtl/bist_ag_timer.sv
module bist_ag_timer
  import bist_ag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [WAIT_W-1:0] waits,
  output logic              adv
);

  logic [WAIT_W-1:0] waits_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [WAIT_W-1:0] wlast;

  assign wlast = WAIT_W'(waits_q - 5'd1);
  assign adv   = run && (wcnt_q == wlast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waits_q <= 5'd2;
      wcnt_q  <= '0;
    end else if (load) begin
      waits_q <= waits;
      wcnt_q  <= '0;
    end else if (run) begin
      if (adv) wcnt_q <= '0;
      else     wcnt_q <= wcnt_q + 5'd1;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (wcnt_q < waits_q)); // R7

  AST_WAIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (waits_q >= 5'd2)); // R8

endmodule

// File: rtl/bist_ag_counter.sv
module bist_ag_counter #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dir_down,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             at_end
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             down_q;

  assign idx    = idx_q;
  assign at_end = down_q ? (idx_q == '0) : (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      last_q <= last_idx;
      down_q <= dir_down;
      idx_q  <= dir_down ? last_idx : '0;
    end else if (adv && !at_end) begin
      if (down_q) idx_q <= idx_q - 1'b1;
      else        idx_q <= idx_q + 1'b1;
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_q); // R2

endmodule

// File: rtl/bist_ag_map.sv
module bist_ag_map
  import bist_ag_pkg::*;
#(
  parameter int IDX_W = 11
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             alt,
  output logic [IDX_W-1:0] addr
);

  assign addr = {idx[IDX_W-1:2], low_col(idx[1:0], alt)};

endmodule

// File: rtl/bist_ag_bg.sv
module bist_ag_bg #(
  parameter int DATA_W = 38
) (
  input  logic [3:0]        seed,
  output logic [DATA_W-1:0] bg
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_rep
    assign bg[b] = seed[b % 4];
  end

endmodule

// File: rtl/bist_addr_gen.sv
module bist_addr_gen
  import bist_ag_pkg::*;
#(
  parameter int COL_W  = 2,
  parameter int DATA_W = 38,
  localparam int ADDR_W = ROW_BITS + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              dir_down_i,
  input  logic [2:0]        row_code_i,
  input  logic              lsb_alt_i,
  input  logic              lat_sel_i,
  input  logic [3:0]        data_lat_i,
  input  logic [1:0]        tag_lat_i,
  input  logic [3:0]        seed_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              access_o,
  output logic [DATA_W-1:0] bg_data_o,
  output logic              pass_end_o,
  output logic              cfg_err_o
);

  logic              run_q, pass_end_q, cfg_err_q, alt_q;
  logic [3:0]        seed_q;
  logic              load, adv, at_end;
  logic [WAIT_W-1:0] waits;
  logic [ADDR_W:0]   span, span_m1;
  logic [ADDR_W-1:0] last_idx, idx;

  assign load     = start_i && !run_q;
  assign waits    = lat_sel_i ? narrow_waits(tag_lat_i) : wide_waits(data_lat_i);
  assign span     = {rows_of(row_code_i), {COL_W{1'b0}}};
  assign span_m1  = span - (ADDR_W+1)'(1);
  assign last_idx = span_m1[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      pass_end_q <= 1'b0;
      cfg_err_q  <= 1'b0;
      alt_q      <= 1'b0;
      seed_q     <= '0;
    end else begin
      pass_end_q <= 1'b0;
      if (load) begin
        run_q     <= 1'b1;
        cfg_err_q <= row_code_bad(row_code_i);
        alt_q     <= lsb_alt_i;
        seed_q    <= seed_i;
      end else if (adv && at_end) begin
        run_q      <= 1'b0;
        pass_end_q <= 1'b1;
      end
    end
  end

  bist_ag_timer u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run_q), .waits(waits), .adv(adv)
  );

  bist_ag_counter #(.IDX_W(ADDR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .dir_down(dir_down_i),
    .last_idx(last_idx), .adv(adv), .idx(idx), .at_end(at_end)
  );

  bist_ag_map #(.IDX_W(ADDR_W)) u_map (
    .idx(idx), .alt(alt_q), .addr(addr_o)
  );

  bist_ag_bg #(.DATA_W(DATA_W)) u_bg (
    .seed(seed_q), .bg(bg_data_o)
  );

  assign access_o   = run_q;
  assign pass_end_o = pass_end_q;
  assign cfg_err_o  = cfg_err_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !adv) |=> $stable(addr_o)); // R7

  AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end_o |=> !pass_end_o); // R9

  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end_o |-> !access_o); // R9

  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (load && row_code_i > 3'd5) |=> cfg_err_o); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i && !adv) |=> (access_o && $stable(addr_o) && $stable(bg_data_o))); // R11

  AST_FIRST_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> access_o); // R12

endmodule

// File: tb/tb_bist_addr_gen.sv
module tb_bist_addr_gen;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 2;
  localparam int DATA_W = 10;
  localparam int ADDR_W = 9 + COL_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic              dir_down_i = 1'b0;
  logic [2:0]        row_code_i = '0;
  logic              lsb_alt_i = 1'b0;
  logic              lat_sel_i = 1'b0;
  logic [3:0]        data_lat_i = '0;
  logic [1:0]        tag_lat_i = '0;
  logic [3:0]        seed_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic              access_o;
  logic [DATA_W-1:0] bg_data_o;
  logic              pass_end_o;
  logic              cfg_err_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_addr_gen #(.COL_W(COL_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_down_i(dir_down_i),
    .row_code_i(row_code_i), .lsb_alt_i(lsb_alt_i), .lat_sel_i(lat_sel_i),
    .data_lat_i(data_lat_i), .tag_lat_i(tag_lat_i), .seed_i(seed_i),
    .addr_o(addr_o), .access_o(access_o), .bg_data_o(bg_data_o),
    .pass_end_o(pass_end_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_waits(input bit lsel, input int dl, input int tl);
    int t[4] = '{2, 2, 3, 4};
    if (lsel) return t[tl];
    return (dl <= 1) ? 2 : dl + 1;
  endfunction

  task automatic do_pass(input int code, input bit dn, input bit alt, input bit lsel,
                         input int dl, input int tl, input logic [3:0] sd,
                         input bit disturb, input string req);
    int rows, total, w, bad_a, bad_s, first_act, first_exp;
    logic [DATA_W-1:0] ebg;
    rows  = (code >= 6) ? 512 : (16 << code);
    total = rows * (1 << COL_W);
    w     = exp_waits(lsel, dl, tl);
    for (int b = 0; b < DATA_W; b++) ebg[b] = sd[b % 4];
    row_code_i = 3'(code); dir_down_i = dn; lsb_alt_i = alt; lat_sel_i = lsel;
    data_lat_i = 4'(dl); tag_lat_i = 2'(tl); seed_i = sd;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    bad_a = 0; bad_s = 0; first_act = 0; first_exp = 0;
    for (int i = 0; i < total; i++) begin
      for (int j = 0; j < w; j++) begin
        int k, lin, el, ea;
        k   = dn ? (total - 1 - i) : i;
        lin = k % 4;
        el  = alt ? (lin ^ (lin >> 1)) : lin;
        ea  = (k / 4) * 4 + el;
        if (int'(addr_o) != ea) begin
          if (bad_a == 0) begin first_act = int'(addr_o); first_exp = ea; end
          bad_a++;
        end
        if (!access_o || pass_end_o || bg_data_o != ebg) bad_s++;
        if (disturb && i == total/2 && j == 0) begin
          start_i = 1'b1; row_code_i = 3'd5; dir_down_i = !dn; lsb_alt_i = !alt;
          lat_sel_i = !lsel; data_lat_i = 4'd15; tag_lat_i = 2'd3; seed_i = ~sd;
        end else begin
          start_i = 1'b0;
        end
        @(negedge clk);
      end
    end
    chk(bad_a == 0, {req, " address sequence"}, first_act, first_exp);
    chk(bad_s == 0, {req, " strobe/hold/background during pass"}, bad_s, 0);
    chk(!access_o && pass_end_o, "R9 end-of-pass after last access", {access_o, pass_end_o}, 1);
    chk(cfg_err_o == (code >= 6), "R3 reserved-code flag", cfg_err_o, (code >= 6));
    chk(bg_data_o == ebg, "R10 background after pass", int'(bg_data_o), int'(ebg));
    @(negedge clk);
    chk(!pass_end_o && !access_o, "R9 single pulse then idle", {access_o, pass_end_o}, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addr_o == '0 && !access_o && !pass_end_o && !cfg_err_o && bg_data_o == '0,
        "R1 reset state", {access_o, pass_end_o, cfg_err_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R4 R5 R6 R12: every row code, both directions, both low-bit orders
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 4; m++)
        do_pass(c, m[0], m[1], 1'b0, 0, 0, 4'(c + 3), 1'b0,
                m[1] ? "R5 alt order" : (m[0] ? "R6 down" : "R2 R4 R12 up"));
    // R3 cleared by a legal code
    do_pass(1, 1'b0, 1'b0, 1'b0, 1, 0, 4'hA, 1'b0, "R3 legal after reserved");
    // R7 all wide-array latency codes
    for (int d = 0; d < 16; d++)
      do_pass(0, d[0], d[1], 1'b0, d, 0, 4'(d), 1'b0, "R7 wide latency");
    // R8 all narrow-array latency codes
    for (int t = 0; t < 4; t++)
      do_pass(0, t[0], 1'b1, 1'b1, 15, t, 4'h5, 1'b0, "R8 narrow latency");
    // R10 R11 disturbance in mid-pass
    do_pass(1, 1'b0, 1'b1, 1'b0, 3, 0, 4'b1001, 1'b1, "R11 start ignored R10");
    do_pass(0, 1'b1, 1'b0, 1'b1, 0, 2, 4'b0110, 1'b1, "R11 down ignored R10");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule